// File: doc/BRIEF.md
# Burst Address Sequencer with Dual Strobes

This block holds the registered word address of a synchronous burst memory and produces the follow-on addresses of a four-beat burst. On each rising clock edge it does one of three things. It loads a fresh external address, it advances the burst, or it keeps the address it already holds. Two active-low address strobes can start a load, and each one is gated by the chip enables in a different way. One strobe is meant for a processor and the other for a memory controller.

During a burst only the low burst-count bits change, and the upper address bits stay fixed. The offset comes from a start offset, latched at load time, combined with a beat counter. A static select input picks how the two are combined. With interleaved order the offset is the start offset XOR the counter. With linear order it is the start offset plus the counter, modulo the burst length. A parameter can also fix the order at build time, in which case the select input is not used.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, `addr_out` is all zeros.
- R2: When `pstrb_n` is sampled low while `ce_main_n` is low, `ce_hi` is high and `ce_lo_n` is low, the next `addr_out` equals the sampled `addr_in`. This holds whatever `cstrb_n` and `adv_n` are.
- R3: A high `ce_main_n` blocks a load by `pstrb_n`. A `pstrb_n` load is also blocked when either secondary enable (`ce_hi`, `ce_lo_n`) is inactive. A blocked load leaves `addr_out` unchanged.
- R4: When `cstrb_n` is sampled low and `pstrb_n` is sampled high, with `ce_hi` high and `ce_lo_n` low, the next `addr_out` equals `addr_in`. `ce_main_n` does not matter for this load. With either secondary enable inactive, `addr_out` holds.
- R5: A low `cstrb_n` has no effect on an edge where `pstrb_n` is also sampled low. If the `pstrb_n` load on that edge is blocked, `addr_out` holds.
- R6: `adv_n` is ignored on any edge where either strobe is sampled low. A load on that edge still produces the start offset, and a blocked strobe still holds.
- R7: When `adv_n` is sampled low and both strobes are sampled high, the burst advances one beat. Bits [18:2] of `addr_out` do not change during the burst.
- R8: With `order_ilv` high, the low two bits of `addr_out` are the start offset XOR the beat count. For example, start 1 gives 1,0,3,2 and start 3 gives 3,2,1,0.
- R9: With `order_ilv` low, the low two bits of `addr_out` are (start offset + beat count) mod 4. For example, start 1 gives 1,2,3,0.
- R10: After four advances, the low bits return to the start offset.
- R11: With no load and `adv_n` high, `addr_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | 19 | External word address |
| pstrb_n | input | 1 | Processor address strobe, active low |
| cstrb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_main_n | input | 1 | Master chip enable, active low |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce_lo_n | input | 1 | Secondary chip enable, active low |
| order_ilv | input | 1 | Burst order select: 1 interleaved, 0 linear |
| addr_out | output | 19 | Current array address |

## Verification
The bench builds the block with its default parameters: a 19-bit address, a 2-bit burst count and the order taken from the select pin. Because the order comes from the pin, one build can reach both the XOR and the additive sequences by changing `order_ilv` between bursts. With the 2-bit count, a four-beat wrap is short enough to check every beat against a model. The 17 fixed upper bits are loaded with distinct patterns, so any leak of the count into them shows up in the comparison.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_LOAD = 2'd1,
      ACT_STEP = 2'd2
   } seq_act_e;

   localparam int ORDER_PIN        = 0;
   localparam int ORDER_LINEAR     = 1;
   localparam int ORDER_INTERLEAVE = 2;
endpackage

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl
   import burst_seq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     pstrb_n,
   input  logic     cstrb_n,
   input  logic     adv_n,
   input  logic     ce_main_n,
   input  logic     ce_hi,
   input  logic     ce_lo_n,
   output seq_act_e act
);
   logic sec_ok;
   logic proc_fire;
   logic ctrl_fire;
   logic both_idle;

   // Secondary enables gate both strobes. The master enable gates only the processor strobe.
   assign sec_ok    = ce_hi & ~ce_lo_n;
   assign proc_fire = ~pstrb_n & ~ce_main_n & sec_ok;
   // The controller strobe counts only while the processor strobe is idle.
   assign ctrl_fire = ~cstrb_n & pstrb_n & sec_ok;
   assign both_idle = pstrb_n & cstrb_n;

   always_comb begin
      if (proc_fire || ctrl_fire)
         act = ACT_LOAD;
      else if (both_idle && !adv_n)
         act = ACT_STEP;
      else
         act = ACT_HOLD;
   end

   // R6: no advance while any strobe is low
   assert_no_step_on_strobe_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!pstrb_n || !cstrb_n) |-> (act != ACT_STEP));

   // R3: blocked processor strobe with idle controller strobe never loads
   assert_master_blocks_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!pstrb_n && ce_main_n) |-> (act != ACT_LOAD));
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W  = 19,
   parameter int BURST_W = 2,
   localparam int UP_W   = ADDR_W - BURST_W
)(
   input  logic               clk,
   input  logic               rst_n,
   input  seq_act_e           act,
   input  logic [ADDR_W-1:0]  addr_in,
   output logic [UP_W-1:0]    upper_q,
   output logic [BURST_W-1:0] start_q,
   output logic [BURST_W-1:0] beat_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upper_q <= '0;
         start_q <= '0;
         beat_q  <= '0;
      end else begin
         unique case (act)
            ACT_LOAD: begin
               upper_q <= addr_in[ADDR_W-1:BURST_W];
               start_q <= addr_in[BURST_W-1:0];
               beat_q  <= '0;
            end
            ACT_STEP: beat_q <= beat_q + 1'b1;
            default:  ;
         endcase
      end
   end

   // R2 / R4: a load restarts the beat count and captures the upper address bits
   assert_load_restart_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_LOAD) |=> (beat_q == '0 && upper_q == $past(addr_in[ADDR_W-1:BURST_W])));

   // R7: an advance moves the count by one and leaves the upper bits alone
   assert_step_one_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_STEP) |=> (beat_q == BURST_W'($past(beat_q) + 1'b1) && $stable(upper_q)
                              && $stable(start_q)));

   // R11: a hold keeps all registered state
   assert_hold_state_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_HOLD) |=> ($stable(beat_q) && $stable(upper_q) && $stable(start_q)));
endmodule

// File: rtl/burst_order_mix.sv
module burst_order_mix
   import burst_seq_pkg::*;
#(
   parameter int BURST_W    = 2,
   parameter int ORDER_MODE = ORDER_PIN
)(
   input  logic [BURST_W-1:0] start_off,
   input  logic [BURST_W-1:0] beat,
   input  logic               order_ilv,
   output logic [BURST_W-1:0] offset
);
   logic [BURST_W-1:0] lin_off;
   logic [BURST_W-1:0] ilv_off;

   // The sum wraps at the burst length because the result keeps only BURST_W bits.
   assign lin_off = start_off + beat;
   assign ilv_off = start_off ^ beat;

   generate
      if (ORDER_MODE == ORDER_LINEAR) begin : g_lin
         assign offset = lin_off;
      end else if (ORDER_MODE == ORDER_INTERLEAVE) begin : g_ilv
         assign offset = ilv_off;
      end else begin : g_pin
         assign offset = order_ilv ? ilv_off : lin_off;
      end
   endgenerate

   // R8 / R9: beat zero maps to the start offset in every order
   always_comb begin
      if (beat == '0)
         assert_beat0_start_R8 : assert (offset == start_off);
   end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W     = 19,
   parameter int BURST_W    = 2,
   parameter int ORDER_MODE = ORDER_PIN,
   localparam int UP_W      = ADDR_W - BURST_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              pstrb_n,
   input  logic              cstrb_n,
   input  logic              adv_n,
   input  logic              ce_main_n,
   input  logic              ce_hi,
   input  logic              ce_lo_n,
   input  logic              order_ilv,
   output logic [ADDR_W-1:0] addr_out
);
   generate
      if (BURST_W < 1 || BURST_W >= ADDR_W) begin : g_bad_width
         $error("burst_addr_seq: BURST_W must be at least 1 and below ADDR_W");
      end
      if (ORDER_MODE < ORDER_PIN || ORDER_MODE > ORDER_INTERLEAVE) begin : g_bad_mode
         $error("burst_addr_seq: ORDER_MODE out of range");
      end
   endgenerate

   seq_act_e           act;
   logic [UP_W-1:0]    upper_q;
   logic [BURST_W-1:0] start_q;
   logic [BURST_W-1:0] beat_q;
   logic [BURST_W-1:0] offset;

   burst_load_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .pstrb_n   (pstrb_n),
      .cstrb_n   (cstrb_n),
      .adv_n     (adv_n),
      .ce_main_n (ce_main_n),
      .ce_hi     (ce_hi),
      .ce_lo_n   (ce_lo_n),
      .act       (act)
   );

   burst_addr_reg #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .act     (act),
      .addr_in (addr_in),
      .upper_q (upper_q),
      .start_q (start_q),
      .beat_q  (beat_q)
   );

   burst_order_mix #(.BURST_W(BURST_W), .ORDER_MODE(ORDER_MODE)) u_mix (
      .start_off (start_q),
      .beat      (beat_q),
      .order_ilv (order_ilv),
      .offset    (offset)
   );

   assign addr_out = {upper_q, offset};

   // R2 / R4: the cycle after any load shows the captured address unchanged
   assert_load_visible_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_LOAD) |=> (addr_out == $past(addr_in)));

   // R1: address is zero during reset
   always_comb begin
      if (!rst_n)
         assert_reset_zero_R1 : assert (addr_out == '0);
   end
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 19;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic          pstrb_n = 1'b1, cstrb_n = 1'b1, adv_n = 1'b1;
   logic          ce_main_n = 1'b0, ce_hi = 1'b1, ce_lo_n = 1'b0, order_ilv = 1'b1;
   logic [AW-1:0] addr_out;

   int errors = 0;
   int checks = 0;

   logic [AW-1:0] exp_q[$];
   string         tag_q[$];

   logic [AW-3:0] m_up = '0;
   logic [1:0]    m_start = '0;
   logic [1:0]    m_beat = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_addr_seq u0 (
      .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .pstrb_n(pstrb_n), .cstrb_n(cstrb_n),
      .adv_n(adv_n), .ce_main_n(ce_main_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
      .order_ilv(order_ilv), .addr_out(addr_out)
   );

   task automatic cyc(input logic sp, input logic sc, input logic av, input logic cm,
                      input logic ch, input logic cl, input logic [AW-1:0] a,
                      input logic ord, input string tag);
      logic pl, ctl;
      logic [1:0] off;
      @(negedge clk);
      pstrb_n = sp; cstrb_n = sc; adv_n = av; ce_main_n = cm; ce_hi = ch; ce_lo_n = cl;
      addr_in = a; order_ilv = ord;
      pl  = !sp && !cm && ch && !cl;
      ctl = !sc && sp && ch && !cl;
      if (pl || ctl) begin
         m_up = a[AW-1:2]; m_start = a[1:0]; m_beat = 2'd0;
      end else if (sp && sc && !av) begin
         m_beat = m_beat + 2'd1;
      end
      off = ord ? (m_start ^ m_beat) : 2'(m_start + m_beat);
      exp_q.push_back({m_up, off});
      tag_q.push_back(tag);
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [AW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (addr_out !== e) begin
               errors++;
               $display("FAIL %s: addr_out=%h expected=%h", t, addr_out, e);
            end
         end
      end
   end

   initial begin : watchdog
      #(CLK_PERIOD * 5000);
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : driver
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (addr_out !== '0) begin
         errors++;
         $display("FAIL R1: addr_out=%h expected=0", addr_out);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R2: processor load, controller strobe and advance low too
      cyc(0, 0, 0, 0, 1, 0, 19'h5A5A5, 1, "R2 proc load");
      // R11: hold
      cyc(1, 1, 1, 0, 1, 0, 19'h00000, 1, "R11 hold");
      cyc(1, 1, 1, 1, 0, 1, 19'h7FFFF, 0, "R11 hold lin");
      // R3: master enable blocks processor load
      cyc(0, 1, 1, 1, 1, 0, 19'h12345, 1, "R3 master blocks");
      cyc(0, 1, 1, 0, 0, 0, 19'h12345, 1, "R3 ce_hi blocks");
      cyc(0, 1, 1, 0, 1, 1, 19'h12345, 1, "R3 ce_lo_n blocks");
      // R5/R6: blocked proc with ctrl low and adv low
      cyc(0, 0, 0, 1, 1, 0, 19'h2AAAA, 1, "R5 R6 blocked both");
      // R4: controller load with master inactive
      cyc(1, 0, 1, 1, 1, 0, 19'h3C3C1, 1, "R4 ctrl load");
      cyc(1, 0, 1, 0, 0, 0, 19'h11111, 1, "R4 ctrl blocked");
      // R8: interleaved from start 1, then R10 wrap
      cyc(1, 1, 0, 0, 1, 0, 19'h0, 1, "R8 ilv beat1");
      cyc(1, 1, 0, 0, 1, 0, 19'h0, 1, "R8 ilv beat2");
      cyc(1, 1, 0, 0, 1, 0, 19'h0, 1, "R8 R7 ilv beat3");
      cyc(1, 1, 0, 0, 1, 0, 19'h0, 1, "R10 wrap ilv");
      // R8 start 3
      cyc(0, 1, 0, 0, 1, 0, 19'h4F0F3, 1, "R6 load ignores adv");
      for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 1, 0, 19'h0, 1, "R8 R10 ilv start3");
      // R9: linear from start 1
      cyc(1, 0, 1, 0, 1, 0, 19'h6DB6D, 0, "R4 ctrl load lin");
      for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 1, 0, 19'h0, 0, "R9 R10 lin start1");
      // R9: linear from start 2, hold midway
      cyc(0, 1, 1, 0, 1, 0, 19'h0ABCE, 0, "R2 load lin");
      cyc(1, 1, 0, 0, 1, 0, 19'h0, 0, "R9 lin beat1");
      cyc(1, 1, 1, 0, 1, 0, 19'h0, 0, "R11 hold mid burst");
      cyc(1, 1, 0, 0, 1, 0, 19'h0, 0, "R9 lin beat2");
      cyc(1, 1, 0, 0, 1, 0, 19'h0, 0, "R9 lin beat3");
      // R6: strobe low blocked stops advance
      cyc(1, 0, 0, 0, 0, 1, 19'h0, 0, "R6 ctrl blocked no step");
      cyc(0, 0, 0, 0, 1, 0, 19'h7FFFF, 1, "R2 R5 proc over ctrl");
      cyc(1, 1, 0, 0, 1, 0, 19'h0, 1, "R8 ilv start3 beat1");
      cyc(1, 1, 1, 0, 1, 0, 19'h0, 1, "R11 final hold");

      repeat (3) @(posedge clk);
      #2;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule